// File: doc/BRIEF.md
# Two-Base Complement Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product one clock after the operands are presented. Rather than forming a grid of partial products, it rounds each operand up to its own power of two and works with the shortfall of each operand from that power. The larger operand is measured against its own power of two, and so is the smaller. The product is then rebuilt from one small multiply of the two shortfalls plus one shifted subtraction.

Because the two operands may sit under different powers of two, the smaller operand's shortfall is scaled by the difference of the two exponents before it is taken away from the larger operand. That difference is then scaled by the smaller exponent and added to the shortfall product. A zero operand bypasses this path and yields zero. A single output register gives the block a fixed latency of one cycle. That register is reset asynchronously.

Top module: `nk_mult`

## Requirements
- R1: For every pair of 8-bit inputs, `prod_o` equals the unsigned product `x_i * y_i`, with the inputs sampled on one rising clock edge and the product visible after that edge.
- R2: The result does not depend on operand order: `x_i = p, y_i = q` and `x_i = q, y_i = p` give the same product. Internally, the operand routed as the larger is never below the one routed as the smaller.
- R3: An operand that is an exact power of two (1, 2, 4 … 128) is its own base with zero shortfall, and the product is the other operand shifted left by that exponent.
- R4: If either input is zero, `prod_o` is zero after the next edge.
- R5: Operands that share the same power-of-two bracket, where the exponent difference is zero, multiply correctly (for example 5 × 3 = 0x000F and 200 × 150 = 0x7530).
- R6: Operands with the widest shortfalls multiply correctly, including 129 × 129 = 0x4101, 129 × 255 = 0x807F and 255 × 255 = 0xFE01.
- R7: While `rst_ni` is low, `prod_o` is 0x0000 whatever the inputs are.
- R8: When the inputs are held for consecutive edges, `prod_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the inputs are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the product register |
| x_i | input | 8 | First unsigned operand |
| y_i | input | 8 | Second unsigned operand |
| prod_o | output | 16 | Registered unsigned product |

## Verification
Every internal fault lands in the one output register, so it shows in `prod_o` on the cycle after the offending inputs are applied. A wrong base or exponent for the larger operand corrupts the product only in some brackets, and a swapped ordering fails only for the operand pairs it touches. For that reason all 65,536 pairs are driven back to back, and each result is compared with a behavioural product one cycle later. The directed pairs then cover swapped order, powers of two, zero, and the widest shortfalls.

// File: rtl/nk_pkg.sv
package nk_pkg;

    // Default operand width of the multiplier.
    localparam int unsigned NK_OP_W = 8;

    // Bits needed to hold an exponent in the range 0..w.
    function automatic int unsigned nk_exp_w(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/nk_order.sv
// Magnitude compare: route the larger operand to op_hi_o.
module nk_order #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] op_hi_o,
    output logic [W-1:0] op_lo_o
);

    logic x_ge_y;

    always_comb begin
        x_ge_y  = (x_i >= y_i);
        op_hi_o = x_ge_y ? x_i : y_i;
        op_lo_o = x_ge_y ? y_i : x_i;
    end

endmodule

// File: rtl/nk_pow_index.sv
// Turns a one-hot power of two into its exponent.
module nk_pow_index #(
    parameter int unsigned BW = 9,
    parameter int unsigned EW = 4
) (
    input  logic [BW-1:0] base_i,
    output logic [EW-1:0] expo_o
);

    always_comb begin
        expo_o = '0;
        for (int i = 0; i < BW; i++) begin
            if (base_i[i]) begin
                expo_o = EW'(i);
            end
        end
    end

endmodule

// File: rtl/nk_base.sv
// Rounds an operand up to a power of two, then gives the shortfall and the exponent.
module nk_base #(
    parameter int unsigned W  = 8,
    parameter int unsigned EW = 4
) (
    input  logic [W-1:0]  op_i,
    output logic [W-1:0]  short_o,
    output logic [EW-1:0] expo_o
);

    localparam int unsigned STG = $clog2(W);

    logic [W-1:0] smear [0:STG];
    logic [W:0]   rounded;
    logic [W:0]   base;
    logic         is_pow2;

    assign smear[0] = op_i - W'(1);

    generate
        for (genvar k = 0; k < STG; k++) begin : g_smear
            assign smear[k+1] = smear[k] | (smear[k] >> (1 << k));
        end
    endgenerate

    always_comb begin
        rounded = {1'b0, smear[STG]} + (W+1)'(1);
        is_pow2 = (op_i != '0) && ((op_i & (op_i - W'(1))) == '0);
        base    = is_pow2 ? {1'b0, op_i} : rounded;
        // Low W bits suffice: the shortfall stays below 2^(W-1).
        short_o = base[W-1:0] - op_i;
    end

    nk_pow_index #(
        .BW (W + 1),
        .EW (EW)
    ) u_pidx (
        .base_i (base),
        .expo_o (expo_o)
    );

endmodule

// File: rtl/nk_shl.sv
// Logarithmic left barrel shifter.
module nk_shl #(
    parameter int unsigned IW = 8,
    parameter int unsigned OW = 16,
    parameter int unsigned SW = 4
) (
    input  logic [IW-1:0] din_i,
    input  logic [SW-1:0] sh_i,
    output logic [OW-1:0] dout_o
);

    logic [OW-1:0] lvl [0:SW];

    assign lvl[0] = OW'(din_i);

    generate
        for (genvar k = 0; k < SW; k++) begin : g_lvl
            assign lvl[k+1] = sh_i[k] ? (lvl[k] << (1 << k)) : lvl[k];
        end
    endgenerate

    assign dout_o = lvl[SW];

endmodule

// File: rtl/nk_mult.sv
// Two-base complement multiplier with a registered output.
module nk_mult #(
    parameter int unsigned W = nk_pkg::NK_OP_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] prod_o
);

    localparam int unsigned EW = nk_pkg::nk_exp_w(W);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned MW = 2 * W - 2;

    typedef struct packed {
        logic [PW-1:0] prod;
    } nk_state_t;

    nk_state_t state_d, state_q;

    logic [W-1:0]  op_hi, op_lo;
    logic [W-1:0]  short_v [0:1];
    logic [EW-1:0] expo_v  [0:1];
    logic [W-1:0]  ops     [0:1];
    logic [EW-1:0] gap;
    logic [W-1:0]  lo_scaled;
    logic [W-1:0]  diff;
    logic [PW-1:0] sub_part;
    logic [MW-1:0] mul_part;

    nk_order #(.W(W)) u_order (
        .x_i     (x_i),
        .y_i     (y_i),
        .op_hi_o (op_hi),
        .op_lo_o (op_lo)
    );

    assign ops[0] = op_hi;
    assign ops[1] = op_lo;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_base
            nk_base #(.W(W), .EW(EW)) u_base (
                .op_i    (ops[g]),
                .short_o (short_v[g]),
                .expo_o  (expo_v[g])
            );
        end
    endgenerate

    // The larger operand's exponent is never below the smaller one's.
    assign gap = expo_v[0] - expo_v[1];

    nk_shl #(.IW(W), .OW(W), .SW(EW)) u_scale (
        .din_i  (short_v[1]),
        .sh_i   (gap),
        .dout_o (lo_scaled)
    );

    assign diff = op_hi - lo_scaled;

    nk_shl #(.IW(W), .OW(PW), .SW(EW)) u_place (
        .din_i  (diff),
        .sh_i   (expo_v[1]),
        .dout_o (sub_part)
    );

    assign mul_part = MW'(short_v[0]) * MW'(short_v[1]);

    always_comb begin
        state_d = state_q;
        if (op_lo == '0) begin
            state_d.prod = '0;
        end else begin
            state_d.prod = sub_part + PW'(mul_part);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign prod_o = state_q.prod;

endmodule

// File: rtl/nk_mult_chk.sv
module nk_mult_chk #(
    parameter int unsigned W = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [W-1:0]   x_i,
    input logic [W-1:0]   y_i,
    input logic [2*W-1:0] prod_o,
    input logic [W-1:0]   op_hi,
    input logic [W-1:0]   op_lo
);

    // R1
    p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |->
        prod_o == ((2*W)'($past(x_i)) * (2*W)'($past(y_i))));

    // R2
    p_ordered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_hi >= op_lo);

    // R4
    p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && ($past(x_i) == '0 || $past(y_i) == '0)) |->
        prod_o == '0);

    // R7
    p_reset_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> prod_o == '0);

    // R8
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $stable(x_i) && $stable(y_i)) |=> $stable(prod_o));

endmodule

bind nk_mult nk_mult_chk #(.W(W)) u_nk_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .y_i    (y_i),
    .prod_o (prod_o),
    .op_hi  (op_hi),
    .op_lo  (op_lo)
);

// File: tb/tb_nk_mult.sv
module tb_nk_mult;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  x_i = 8'd0;
    logic [7:0]  y_i = 8'd0;
    logic [15:0] prod_o;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];

    nk_mult dut (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .x_i    (x_i),
        .y_i    (y_i),
        .prod_o (prod_o)
    );

    always #10 clk_i = ~clk_i;   // 50 MHz

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Check the result due from the previous step, then apply new operands.
    task automatic step(input int xv, input int yv, input string tag);
        @(negedge clk_i);
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), int'(prod_o), exp_q.pop_front());
        end
        x_i = xv[7:0];
        y_i = yv[7:0];
        exp_q.push_back(xv * yv);
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk_i);
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), int'(prod_o), exp_q.pop_front());
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R7: reset holds the output at zero even with busy inputs
        x_i = 8'd255;
        y_i = 8'd255;
        repeat (3) begin
            @(negedge clk_i);
            check("R7 reset", int'(prod_o), 0);
        end
        rst_ni = 1'b1;

        // R5: same bracket, including the worked example
        step(5, 3, "R5 5x3");
        step(200, 150, "R5 200x150");
        step(100, 100, "R5 equal");
        // R2: swapped order
        step(3, 5, "R2 3x5");
        step(150, 200, "R2 150x200");
        step(17, 240, "R2 17x240");
        step(240, 17, "R2 240x17");
        // R3: powers of two
        step(128, 77, "R3 128x77");
        step(1, 255, "R3 1x255");
        step(64, 64, "R3 64x64");
        step(2, 129, "R3 2x129");
        // R4: zero operands
        step(0, 200, "R4 0x200");
        step(255, 0, "R4 255x0");
        step(0, 0, "R4 0x0");
        // R6: widest shortfalls
        step(129, 129, "R6 129x129");
        step(129, 255, "R6 129x255");
        step(255, 255, "R6 255x255");
        step(129, 3, "R6 129x3");
        // R8: held inputs keep the product
        step(77, 91, "R8 hold");
        step(77, 91, "R8 hold");
        step(77, 91, "R8 hold");
        // R1: every pair
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                step(i, j, "R1 sweep");
            end
        end
        flush();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule